// File: doc/BRIEF.md
# Execute Stage: ALU and Branch Unit

This block is the execute stage of a small 16-bit word machine. Each cycle it may accept one instruction that has already been decoded. It takes an 8-bit opcode, up to three operand values (`a`, `b`, `c`), the address of the next instruction and the value on top of the stack. It works out everything that instruction asks of the rest of the core. That covers:

- a write-back value for operand `a`;
- a redirect of the program counter;
- a push or pop request for the stack;
- a halt with an exit code;
- a system-call strobe.

All outputs are registered. They present the effect of an instruction on the clock edge that follows the cycle in which it was offered with `in_valid` high. Operand fetch, the register file, stack storage and the devices behind system calls lie outside the block. The surrounding core uses `wb_en` to store `wb_data` into whatever operand `a` named. It follows `jump_taken` and `jump_addr` to redirect fetch, and it services the stack and syscall strobes.

Top module: `exec_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is forced to zero on that edge.
- R2: The outputs reflect the instruction offered in the previous cycle. `out_valid` equals the previous cycle's `in_valid`. When `out_valid` is low, all strobes (`wb_en`, `jump_taken`, `push_req`, `pop_req`, `halt`, `sys_req`, `div_err`) are low.
- R3: Opcodes 13 (add), 14 (subtract) and 15 (multiply) write `a+b`, `a-b` and `a*b` back, keeping only the low 16 bits (modulo 65536), with `wb_en` high.
- R4: Opcode 16 (remainder) writes `a % b`. When `b` is 0 it writes `a` unchanged and raises `div_err`; `div_err` is low for every other case.
- R5: Opcodes 17, 18, 19 and 20 write `a&b`, `a|b`, `~a` and `a^b` respectively.
- R6: Opcodes 21 and 22 write `a` logically shifted left or right by `b` bits. A shift amount of 16 or more gives 0.
- R7: Opcode 3 (move) writes `b` into `a`.
- R8: Opcodes 5 to 10 compare `b` with `c` as unsigned numbers, testing equal, not equal, greater, greater-or-equal, less and less-or-equal in that order. When the test holds, `jump_taken` is high with `jump_addr` = `a`. No compare opcode writes back.
- R9: Opcode 4 always jumps to `a`. Opcode 11 jumps to `a` and pushes `next_addr` (the address after the call). Opcode 12 pops and jumps to `stack_top`.
- R10: Opcode 23 pushes `a` (`push_data` = `a`). Opcode 24 pops and writes `stack_top` back into `a`. A push and a pop are never requested together.
- R11: Opcode 1 raises `halt` with `exit_code` = `a`. Opcode 2 raises `sys_req` with `sys_id` = `a`. Opcode 0 and every opcode above 24 produce no strobe at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is offered this cycle |
| opcode | input | 8 | Operation code |
| opnd_a | input | 16 | Resolved value of operand a |
| opnd_b | input | 16 | Resolved value of operand b |
| opnd_c | input | 16 | Resolved value of operand c |
| next_addr | input | 16 | Address of the instruction after this one |
| stack_top | input | 16 | Current top-of-stack word |
| out_valid | output | 1 | Outputs carry a result |
| wb_en | output | 1 | Write `wb_data` to operand a |
| wb_data | output | 16 | Write-back value |
| jump_taken | output | 1 | Redirect fetch |
| jump_addr | output | 16 | Redirect target |
| push_req | output | 1 | Push `push_data` onto the stack |
| push_data | output | 16 | Word to push |
| pop_req | output | 1 | Remove the top stack word |
| halt | output | 1 | Stop execution |
| exit_code | output | 16 | Value returned on halt |
| sys_req | output | 1 | System-call strobe |
| sys_id | output | 16 | System-call number |
| div_err | output | 1 | Remainder by zero attempted |

## Verification
The compare tests use values with the top bit set, so a design that compared as signed numbers would take the wrong branches. Add, subtract and multiply are driven past 65535 and below zero, which catches an adder or multiplier that does not wrap. Remainder by zero and shift counts of exactly 16 and far beyond are run to expose a result that is garbage, or a shift that uses only the low bits of `b`. Call, return, push and pop each check the exact push word and jump target, which would show a call that saves its own address or a return that ignores the stack. Idle cycles and out-of-range opcodes confirm that no strobe leaks.

// File: rtl/exec_pkg.sv
// Shared opcode encoding and write-back source selection for the execute stage.
// Assumes the opcode sits in an 8-bit field; values above OP_POP are undefined.
package exec_pkg;
    localparam int OPC_W = 8;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP = 8'd0,  OP_EXT = 8'd1,  OP_SYS = 8'd2,  OP_MOV = 8'd3,
        OP_JMP = 8'd4,  OP_JEQ = 8'd5,  OP_JNE = 8'd6,  OP_JGT = 8'd7,
        OP_JGE = 8'd8,  OP_JLT = 8'd9,  OP_JLE = 8'd10, OP_JSR = 8'd11,
        OP_RET = 8'd12, OP_ADD = 8'd13, OP_SUB = 8'd14, OP_MUL = 8'd15,
        OP_MOD = 8'd16, OP_AND = 8'd17, OP_ORR = 8'd18, OP_NOT = 8'd19,
        OP_XOR = 8'd20, OP_LSL = 8'd21, OP_LSR = 8'd22, OP_PSH = 8'd23,
        OP_POP = 8'd24
    } op_e;

    typedef enum logic [1:0] {
        WB_ALU   = 2'd0,
        WB_OPNDB = 2'd1,
        WB_STACK = 2'd2
    } wb_src_e;
endpackage

// File: rtl/exec_alu.sv
// Arithmetic and bitwise unit: wraps add/sub/mul to the word width, guards
// remainder against a zero divisor, and saturates shifts of W or more to zero.
// Purely combinational; the caller qualifies hit with its own valid.
module exec_alu
    import exec_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output logic         hit,
    output logic         div_err
);
    localparam int SH_W = $clog2(W);

    logic         shift_wide;
    logic [2*W-1:0] prod;

    // Shift amounts at or above the word width flush the word.
    assign shift_wide = (b >= W[W-1:0]);
    assign prod       = a * b;

    // Select the operation result and flag the opcodes this unit owns.
    always_comb begin
        result  = '0;
        hit     = 1'b1;
        div_err = 1'b0;
        case (op)
            OP_ADD: result = a + b;
            OP_SUB: result = a - b;
            OP_MUL: result = prod[W-1:0];
            OP_MOD: begin
                if (b == '0) begin
                    result  = a;
                    div_err = 1'b1;
                end else begin
                    result = a % b;
                end
            end
            OP_AND: result = a & b;
            OP_ORR: result = a | b;
            OP_NOT: result = ~a;
            OP_XOR: result = a ^ b;
            OP_LSL: result = shift_wide ? '0 : (a << b[SH_W-1:0]);
            OP_LSR: result = shift_wide ? '0 : (a >> b[SH_W-1:0]);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/exec_branch.sv
// Branch unit: unconditional and unsigned compare-and-jump, call and return.
// Assumes the caller supplies the address of the following instruction and
// the current top of stack; returns pull their target from that stack word.
module exec_branch
    import exec_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] stack_top,
    output logic         taken,
    output logic [W-1:0] target,
    output logic         call_push,
    output logic         ret_pop
);
    logic b_eq_c;
    logic b_gt_c;

    // Unsigned relations between operands b and c.
    assign b_eq_c = (b == c);
    assign b_gt_c = (b > c);

    // Decide whether fetch is redirected and where to.
    always_comb begin
        taken     = 1'b0;
        target    = a;
        call_push = 1'b0;
        ret_pop   = 1'b0;
        case (op)
            OP_JMP: taken = 1'b1;
            OP_JEQ: taken = b_eq_c;
            OP_JNE: taken = !b_eq_c;
            OP_JGT: taken = b_gt_c;
            OP_JGE: taken = b_gt_c || b_eq_c;
            OP_JLT: taken = !b_gt_c && !b_eq_c;
            OP_JLE: taken = !b_gt_c;
            OP_JSR: begin
                taken     = 1'b1;
                call_push = 1'b1;
            end
            OP_RET: begin
                taken   = 1'b1;
                ret_pop = 1'b1;
                target  = stack_top;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exec_ctrl.sv
// Control decode for the non-arithmetic opcodes: move, data stack access,
// halt and system call. Assumes undefined opcodes must have no effect.
module exec_ctrl
    import exec_pkg::*;
(
    input  op_e     op,
    output logic    wb_req,
    output wb_src_e wb_src,
    output logic    data_push,
    output logic    data_pop,
    output logic    halt_req,
    output logic    sys_req
);
    // Map each control opcode to its side effects.
    always_comb begin
        wb_req    = 1'b0;
        wb_src    = WB_ALU;
        data_push = 1'b0;
        data_pop  = 1'b0;
        halt_req  = 1'b0;
        sys_req   = 1'b0;
        case (op)
            OP_MOV: begin
                wb_req = 1'b1;
                wb_src = WB_OPNDB;
            end
            OP_PSH: data_push = 1'b1;
            OP_POP: begin
                wb_req   = 1'b1;
                wb_src   = WB_STACK;
                data_pop = 1'b1;
            end
            OP_EXT: halt_req = 1'b1;
            OP_SYS: sys_req  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/exec_unit.sv
// Execute stage top: combines ALU, branch and control decode and registers
// every effect for one cycle. Assumes at most one instruction per cycle and
// that operands arrive already resolved. Synchronous active-low reset.
module exec_unit
    import exec_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [7:0]   opcode,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] opnd_c,
    input  logic [W-1:0] next_addr,
    input  logic [W-1:0] stack_top,
    output logic         out_valid,
    output logic         wb_en,
    output logic [W-1:0] wb_data,
    output logic         jump_taken,
    output logic [W-1:0] jump_addr,
    output logic         push_req,
    output logic [W-1:0] push_data,
    output logic         pop_req,
    output logic         halt,
    output logic [W-1:0] exit_code,
    output logic         sys_req,
    output logic [W-1:0] sys_id,
    output logic         div_err
);
    op_e          op;
    logic [W-1:0] alu_res;
    logic         alu_hit, alu_div_err;
    logic         br_taken, br_call_push, br_ret_pop;
    logic [W-1:0] br_target;
    logic         ct_wb, ct_push, ct_pop, ct_halt, ct_sys;
    wb_src_e      ct_src;
    logic [W-1:0] wb_mux;

    assign op = op_e'(opcode);

    exec_alu #(.W(W)) alu_i (
        .op(op), .a(opnd_a), .b(opnd_b),
        .result(alu_res), .hit(alu_hit), .div_err(alu_div_err)
    );

    exec_branch #(.W(W)) branch_i (
        .op(op), .a(opnd_a), .b(opnd_b), .c(opnd_c), .stack_top(stack_top),
        .taken(br_taken), .target(br_target),
        .call_push(br_call_push), .ret_pop(br_ret_pop)
    );

    exec_ctrl ctrl_i (
        .op(op), .wb_req(ct_wb), .wb_src(ct_src),
        .data_push(ct_push), .data_pop(ct_pop),
        .halt_req(ct_halt), .sys_req(ct_sys)
    );

    // Pick the write-back word from the source control decode names.
    always_comb begin
        case (ct_src)
            WB_OPNDB: wb_mux = opnd_b;
            WB_STACK: wb_mux = stack_top;
            default:  wb_mux = alu_res;
        endcase
    end

    // Register every effect; strobes are qualified by in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            wb_en      <= 1'b0;
            wb_data    <= '0;
            jump_taken <= 1'b0;
            jump_addr  <= '0;
            push_req   <= 1'b0;
            push_data  <= '0;
            pop_req    <= 1'b0;
            halt       <= 1'b0;
            exit_code  <= '0;
            sys_req    <= 1'b0;
            sys_id     <= '0;
            div_err    <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            wb_en      <= in_valid && (alu_hit || ct_wb);
            wb_data    <= in_valid ? wb_mux : '0;
            jump_taken <= in_valid && br_taken;
            jump_addr  <= in_valid ? br_target : '0;
            push_req   <= in_valid && (br_call_push || ct_push);
            push_data  <= in_valid ? (br_call_push ? next_addr : opnd_a) : '0;
            pop_req    <= in_valid && (br_ret_pop || ct_pop);
            halt       <= in_valid && ct_halt;
            exit_code  <= in_valid ? opnd_a : '0;
            sys_req    <= in_valid && ct_sys;
            sys_id     <= in_valid ? opnd_a : '0;
            div_err    <= in_valid && alu_div_err;
        end
    end

    // R2: no strobe without a valid result
    p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(wb_en || jump_taken || push_req || pop_req || halt || sys_req || div_err));

    // R2: a valid result follows an offered instruction by one cycle
    p_one_cycle_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R4: a zero divisor leaves operand a in place
    p_mod_zero_keeps_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (wb_en && wb_data == $past(opnd_a)));

    // R6: wide shifts flush the word
    p_wide_shift_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(opcode) == 8'd21 || $past(opcode) == 8'd22)
         && $past(opnd_b) >= W) |-> (wb_data == '0));

    // R8: a redirect never writes operand a
    p_jump_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        jump_taken |-> !wb_en);

    // R10: push and pop are exclusive
    p_push_pop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req && pop_req));

    // R11: halt, syscall and write-back are mutually exclusive
    p_single_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt, sys_req, wb_en}));
endmodule

// File: tb/exec_unit_tb_top.sv
`timescale 1ns/1ps
module exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, next_addr = '0, stack_top = '0;
    logic        out_valid, wb_en, jump_taken, push_req, pop_req, halt, sys_req, div_err;
    logic [15:0] wb_data, jump_addr, push_data, exit_code, sys_id;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .next_addr(next_addr), .stack_top(stack_top),
        .out_valid(out_valid), .wb_en(wb_en), .wb_data(wb_data),
        .jump_taken(jump_taken), .jump_addr(jump_addr),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
        .halt(halt), .exit_code(exit_code), .sys_req(sys_req),
        .sys_id(sys_id), .div_err(div_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Offer one instruction and sample one cycle later, mid-period.
    task automatic issue(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic [15:0] na, input logic [15:0] st);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; opnd_a = a; opnd_b = b; opnd_c = c;
        next_addr = na; stack_top = st;
        @(posedge clk);
        #5;
        in_valid = 1'b0;
    endtask

    function automatic logic [6:0] strobes();
        return {wb_en, jump_taken, push_req, pop_req, halt, sys_req, div_err};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; opcode = 8'd13; opnd_a = 16'h1;
        @(posedge clk); #5;
        chk("R1", "valid in reset", {31'd0, out_valid}, 0);
        chk("R1", "strobes in reset", {25'd0, strobes()}, 0);
        chk("R1", "data in reset", {wb_data, push_data}, 0);
        in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_timing();
        issue(8'd13, 16'd3, 16'd4, 0, 0, 0);
        chk("R2", "valid after issue", {31'd0, out_valid}, 1);
        @(posedge clk); #5;
        chk("R2", "valid drops when idle", {31'd0, out_valid}, 0);
        chk("R2", "no strobes when idle", {25'd0, strobes()}, 0);
        // output unchanged before the capturing edge
        @(negedge clk);
        in_valid = 1'b1; opcode = 8'd1; opnd_a = 16'h55;
        #5;
        chk("R2", "halt before edge", {31'd0, halt}, 0);
        @(posedge clk); #5;
        in_valid = 1'b0;
        chk("R2", "halt after edge", {31'd0, halt}, 1);
    endtask

    task automatic t_arith();
        issue(8'd13, 16'hFFFF, 16'd2, 0, 0, 0);
        chk("R3", "add wraps", {15'd0, wb_en, wb_data}, {15'd0, 1'b1, 16'h0001});
        issue(8'd14, 16'd1, 16'd2, 0, 0, 0);
        chk("R3", "sub wraps", {15'd0, wb_en, wb_data}, {15'd0, 1'b1, 16'hFFFF});
        issue(8'd15, 16'h1234, 16'h0100, 0, 0, 0);
        chk("R3", "mul low half", {16'd0, wb_data}, 32'h3400);
    endtask

    task automatic t_mod();
        issue(8'd16, 16'd17, 16'd5, 0, 0, 0);
        chk("R4", "remainder", {15'd0, div_err, wb_data}, {15'd0, 1'b0, 16'd2});
        issue(8'd16, 16'hBEEF, 16'd0, 0, 0, 0);
        chk("R4", "zero divisor", {14'd0, div_err, wb_en, wb_data}, {14'd0, 2'b11, 16'hBEEF});
    endtask

    task automatic t_bitwise();
        issue(8'd17, 16'hF0F0, 16'h3C3C, 0, 0, 0);
        chk("R5", "and", {16'd0, wb_data}, 32'h3030);
        issue(8'd18, 16'hF0F0, 16'h3C3C, 0, 0, 0);
        chk("R5", "orr", {16'd0, wb_data}, 32'hFCFC);
        issue(8'd19, 16'hF0F0, 16'h1234, 0, 0, 0);
        chk("R5", "not", {16'd0, wb_data}, 32'h0F0F);
        issue(8'd20, 16'hF0F0, 16'h3C3C, 0, 0, 0);
        chk("R5", "xor", {16'd0, wb_data}, 32'hCCCC);
    endtask

    task automatic t_shift();
        issue(8'd21, 16'h0001, 16'd15, 0, 0, 0);
        chk("R6", "lsl 15", {16'd0, wb_data}, 32'h8000);
        issue(8'd21, 16'h0001, 16'd16, 0, 0, 0);
        chk("R6", "lsl 16", {16'd0, wb_data}, 0);
        issue(8'd22, 16'h8000, 16'd3, 0, 0, 0);
        chk("R6", "lsr 3", {16'd0, wb_data}, 32'h1000);
        issue(8'd22, 16'hFFFF, 16'd40, 0, 0, 0);
        chk("R6", "lsr 40", {16'd0, wb_data}, 0);
    endtask

    task automatic t_mov();
        issue(8'd3, 16'h1111, 16'hA5A5, 0, 0, 0);
        chk("R7", "move", {15'd0, wb_en, wb_data}, {15'd0, 1'b1, 16'hA5A5});
    endtask

    task automatic t_cond();
        logic [15:0] bv[3] = '{16'h8000, 16'h0042, 16'h0001};
        logic [15:0] cv[3] = '{16'h0001, 16'h0042, 16'h8000};
        for (int op = 5; op <= 10; op++) begin
            for (int k = 0; k < 3; k++) begin
                logic exp_t;
                case (op)
                    5:  exp_t = bv[k] == cv[k];
                    6:  exp_t = bv[k] != cv[k];
                    7:  exp_t = bv[k] >  cv[k];
                    8:  exp_t = bv[k] >= cv[k];
                    9:  exp_t = bv[k] <  cv[k];
                    default: exp_t = bv[k] <= cv[k];
                endcase
                issue(op[7:0], 16'h0300 + 16'(op), bv[k], cv[k], 0, 0);
                chk("R8", $sformatf("op %0d case %0d taken", op, k), {31'd0, jump_taken}, {31'd0, exp_t});
                if (exp_t)
                    chk("R8", "target", {16'd0, jump_addr}, {16'd0, 16'h0300 + 16'(op)});
                chk("R8", "no write", {31'd0, wb_en}, 0);
            end
        end
    endtask

    task automatic t_calls();
        issue(8'd4, 16'h1234, 0, 0, 0, 0);
        chk("R9", "jmp", {15'd0, jump_taken, jump_addr}, {15'd0, 1'b1, 16'h1234});
        issue(8'd11, 16'h4000, 0, 0, 16'h0105, 16'h7777);
        chk("R9", "jsr jump", {15'd0, jump_taken, jump_addr}, {15'd0, 1'b1, 16'h4000});
        chk("R9", "jsr push", {14'd0, push_req, pop_req, push_data}, {14'd0, 2'b10, 16'h0105});
        issue(8'd12, 16'h4000, 0, 0, 16'h0999, 16'h0105);
        chk("R9", "ret", {14'd0, jump_taken, pop_req, jump_addr}, {14'd0, 2'b11, 16'h0105});
        chk("R9", "ret no push", {31'd0, push_req}, 0);
    endtask

    task automatic t_stack();
        issue(8'd23, 16'hCAFE, 0, 0, 16'h0200, 0);
        chk("R10", "psh", {14'd0, push_req, pop_req, push_data}, {14'd0, 2'b10, 16'hCAFE});
        chk("R10", "psh no write", {31'd0, wb_en}, 0);
        issue(8'd24, 16'h0000, 0, 0, 0, 16'hD00D);
        chk("R10", "pop", {13'd0, pop_req, push_req, wb_en, wb_data}, {13'd0, 3'b101, 16'hD00D});
    endtask

    task automatic t_misc();
        issue(8'd1, 16'h002A, 0, 0, 0, 0);
        chk("R11", "ext", {15'd0, halt, exit_code}, {15'd0, 1'b1, 16'h002A});
        issue(8'd2, 16'h0006, 0, 0, 0, 0);
        chk("R11", "sys", {14'd0, sys_req, halt, sys_id}, {14'd0, 2'b10, 16'h0006});
        issue(8'd0, 16'h1, 16'h2, 16'h3, 16'h4, 16'h5);
        chk("R11", "nop quiet", {24'd0, out_valid, strobes()}, {24'd0, 1'b1, 7'd0});
        issue(8'd25, 16'h1, 16'h2, 16'h3, 16'h4, 16'h5);
        chk("R11", "opcode 25 quiet", {25'd0, strobes()}, 0);
        issue(8'd200, 16'h1, 16'h1, 16'h1, 16'h4, 16'h5);
        chk("R11", "opcode 200 quiet", {25'd0, strobes()}, 0);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_timing();
        t_arith();
        t_mod();
        t_bitwise();
        t_shift();
        t_mov();
        t_cond();
        t_calls();
        t_stack();
        t_misc();
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule